// File: doc/BRIEF.md
# Half-Bridge Dead-Time Controller

This block sits between a pulse-width controller and the two gate-drive channels of a half-bridge. It takes the controller's high-side and low-side commands, an enable, a fault line, a two-bit policy select and a dead-time value counted in clock cycles. It drives the high-side and low-side outputs so that the two power switches never conduct together, unless the bypass policy is selected.

There are four policies. In the trim policy, any overlap between the commands becomes dead-time and any existing gap passes unchanged. The programmable policy enforces a minimum gap taken from the dead-time input, but it keeps any larger gap the controller already provides. The fixed policy applies the same rule with the largest allowed gap. The bypass policy copies each command straight to its output. The block assumes a 200 MHz clock, so one count equals 5 ns. The fault line models undervoltage or over-temperature shutdown: it drops both outputs at once and latches off until both commands have been seen low.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: Both outputs are low while reset is asserted and while the enable input is low. The enable input passes through the same three-cycle path as the commands.
- R2: Every command edge reaches its output exactly three clock cycles after it is applied, on both channels.
- R3: With mode 2'b00 (trim), if both commands are high together, both outputs stay low for the overlap. A gap of zero or more cycles between the commands is reproduced unchanged at the outputs.
- R4: With mode 2'b01 (programmable), an output turns on only after the opposite output has been low for at least the required count, even when the controller's gap is shorter or negative.
- R5: With mode 2'b01, a controller gap longer than the required count is passed to the outputs unchanged.
- R6: In mode 2'b01, the dead-time input is clamped to the range 5 to 40 cycles. Values below 5 act as 5, and values above 40 act as 40.
- R7: With mode 2'b10 (fixed), the required count is 40 cycles whatever the dead-time input holds. A longer controller gap still wins.
- R8: With mode 2'b11 (bypass), the high-side output follows the high-side command and the low-side output follows the low-side command, including overlap.
- R9: A turn-off is never delayed. An output falls three cycles after its command falls, or in the protecting modes three cycles after the opposite command rises.
- R10: While the fault input is high, both outputs are low within the same cycle, without waiting for a clock edge.
- R11: After fault falls, both outputs stay low until both commands have been sampled low. Normal operation resumes after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 200 MHz nominal |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Output enable; low forces both outputs off |
| fault | input | 1 | Shutdown request; forces both outputs off immediately |
| mode | input | 2 | Policy: 00 trim, 01 programmable, 10 fixed maximum, 11 bypass |
| dt_cycles | input | CNT_W | Requested dead-time in clock cycles for the programmable policy |
| hin | input | 1 | High-side command from the controller |
| lin | input | 1 | Low-side command from the controller |
| ho | output | 1 | High-side drive output |
| lo | output | 1 | Low-side drive output |

## Verification
The main function is exercised by a low-side-off, high-side-on transition in which the controller's gap is swept from negative (overlap) through zero to values above the required count. This sweep separates trimming, enforcing and passing behaviour. Applying the same gap in all four policies shows which policy owns each edge. Dead-time inputs below, inside and above the clamp range tell a clamp fault apart from a counting fault. The fixed policy is driven with a small dead-time input to show that the input is ignored there. The absolute time of the low-side fall confirms that turn-offs are never held back. Directed cases cover enable gating and the fault lockout, including a command that stays high across the fault release.

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl #(
  parameter int CNT_W  = 6,
  parameter int DT_MIN = 5,
  parameter int DT_MAX = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fault,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] dt_cycles,
  input  logic             hin,
  input  logic             lin,
  output logic             ho,
  output logic             lo
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [CNT_W-1:0] MIN_V   = CNT_W'(DT_MIN);
  localparam logic [CNT_W-1:0] MAX_V   = CNT_W'(DT_MAX);
  localparam logic [1:0] M_TRIM  = 2'b00;
  localparam logic [1:0] M_PROG  = 2'b01;
  localparam logic [1:0] M_FIXED = 2'b10;
  localparam logic [1:0] M_PASS  = 2'b11;

  logic [2:0] sync1, sync2;
  logic en_s, hs, ls;
  logic ho_q, lo_q, lock;
  logic ho_n, lo_n, go;
  logic [CNT_W-1:0] ho_off_cnt, lo_off_cnt, dt_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {en, hin, lin};
      sync2 <= sync1;
    end

  assign en_s = sync2[2];
  assign hs   = sync2[1];
  assign ls   = sync2[0];
  assign go   = en_s & ~lock & ~fault;

  always_comb
    if (mode == M_FIXED)       dt_req = MAX_V;
    else if (dt_cycles < MIN_V) dt_req = MIN_V;
    else if (dt_cycles > MAX_V) dt_req = MAX_V;
    else                        dt_req = dt_cycles;

  always_comb begin
    case (mode)
      M_PASS: begin
        ho_n = hs;
        lo_n = ls;
      end
      M_TRIM: begin
        ho_n = hs & ~ls;
        lo_n = ls & ~hs;
      end
      default: begin
        ho_n = hs & ~ls & (ho_q | (~lo_q & (lo_off_cnt >= dt_req)));
        lo_n = ls & ~hs & (lo_q | (~ho_q & (ho_off_cnt >= dt_req)));
      end
    endcase
    if (!go) begin
      ho_n = 1'b0;
      lo_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ho_q       <= 1'b0;
      lo_q       <= 1'b0;
      lock       <= 1'b0;
      ho_off_cnt <= '0;
      lo_off_cnt <= '0;
    end else begin
      ho_q <= ho_n;
      lo_q <= lo_n;
      lock <= fault | (lock & (hs | ls));
      if (fault) begin
        ho_off_cnt <= '0;
        lo_off_cnt <= '0;
      end else begin
        ho_off_cnt <= ho_q ? CNT_W'(1) : (ho_off_cnt == CNT_SAT ? CNT_SAT : ho_off_cnt + 1'b1);
        lo_off_cnt <= lo_q ? CNT_W'(1) : (lo_off_cnt == CNT_SAT ? CNT_SAT : lo_off_cnt + 1'b1);
      end
    end

  assign ho = ho_q & ~fault;
  assign lo = lo_q & ~fault;

  logic [CNT_W-1:0] chk_lo_quiet, chk_ho_quiet;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chk_lo_quiet <= '0;
      chk_ho_quiet <= '0;
    end else begin
      chk_lo_quiet <= lo ? '0 : (chk_lo_quiet == CNT_SAT ? CNT_SAT : chk_lo_quiet + 1'b1);
      chk_ho_quiet <= ho ? '0 : (chk_ho_quiet == CNT_SAT ? CNT_SAT : chk_ho_quiet + 1'b1);
    end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) != M_PASS) |-> !(ho && lo)); // R3

  AST_HO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ho_q) && ($past(mode) == M_PROG || $past(mode) == M_FIXED))
      |-> (chk_lo_quiet >= $past(dt_req))); // R4

  AST_LO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lo_q) && ($past(mode) == M_PROG || $past(mode) == M_FIXED))
      |-> (chk_ho_quiet >= $past(dt_req))); // R7

  AST_OFF_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ho_q && !hs) |=> !ho_q); // R9

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> (!ho && !lo)); // R11

endmodule

// File: tb/hb_deadtime_ctrl_test.sv
`timescale 1ns/1ps
module hb_deadtime_ctrl_test;
  logic clk = 0, rst_n = 0, en = 1, fault = 0, hin = 1, lin = 1;
  logic [1:0] mode = 2'b11;
  logic [5:0] dt = 6'd10;
  logic ho, lo;
  int tests = 0, fails = 0;
  bit done = 0;

  hb_deadtime_ctrl uut (.clk(clk), .rst_n(rst_n), .en(en), .fault(fault), .mode(mode),
    .dt_cycles(dt), .hin(hin), .lin(lin), .ho(ho), .lo(lo));

  always #2.5 clk = ~clk;

  localparam int NV = 12;
  // mode, dt, controller gap (negative = overlap), requirement tag
  localparam int VEC [NV][4] = '{
    '{0, 10,  4, 3}, '{0, 10,  0, 3}, '{0, 10, -6, 3},
    '{1, 10,  2, 4}, '{1, 10, 25, 5}, '{1, 10, -3, 4},
    '{1,  2,  0, 6}, '{1, 60,  0, 6},
    '{2, 10,  3, 7}, '{2, 10, 50, 7},
    '{3, 10,  4, 8}, '{3, 10, -5, 8}};

  function automatic string tag_s(int t);
    case (t)
      3: return "R3"; 4: return "R4"; 5: return "R5";
      6: return "R6"; 7: return "R7"; default: return "R8";
    endcase
  endfunction

  function automatic int exp_gap(int m, int d, int g);
    int req, a;
    req = (m == 2) ? 40 : (d < 5 ? 5 : (d > 40 ? 40 : d));
    a = g < 0 ? -g : g;
    case (m)
      0: return a;
      3: return g;
      default: return a > req ? a : req;
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp, string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(int m, int d, int g, int t);
    int lo_fall = -1, ho_rise = -1, exp_lf;
    mode = m[1:0]; dt = d[5:0]; hin = 0; lin = 1;
    repeat (60) @(negedge clk);
    for (int c = 0; c < 140; c++) begin
      @(negedge clk);
      if (lo_fall < 0 && !lo) lo_fall = c;
      if (ho_rise < 0 && ho) ho_rise = c;
      lin = (c < 20);
      hin = (c >= 20 + g);
    end
    exp_lf = (m != 3 && g < 0) ? 23 + g : 23;
    check(lo_fall == exp_lf, "R9", lo_fall, exp_lf, "low-side fall time");
    check(ho_rise - lo_fall == exp_gap(m, d, g), tag_s(t), ho_rise - lo_fall,
          exp_gap(m, d, g), "output gap");
    hin = 0; lin = 0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ho == 0 && lo == 0, "R1", {ho, lo}, 0, "outputs in reset");
    hin = 0; lin = 0;
    @(negedge clk) rst_n = 1;
    repeat (70) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);

    // R2: rise latency in bypass
    mode = 2'b11; hin = 1;
    repeat (2) @(negedge clk);
    check(ho == 0, "R2", ho, 0, "high-side two cycles after command");
    @(negedge clk);
    check(ho == 1, "R2", ho, 1, "high-side three cycles after command");

    // R1: enable gating
    en = 0;
    repeat (6) @(negedge clk);
    check(ho == 0, "R1", ho, 0, "high-side with enable low");
    en = 1;
    repeat (3) @(negedge clk);
    check(ho == 1, "R1", ho, 1, "high-side after enable returns");

    // R10 / R11: fault
    @(negedge clk) fault = 1;
    #1 check(ho == 0, "R10", ho, 0, "high-side during fault, same cycle");
    @(negedge clk) fault = 0;
    repeat (6) @(negedge clk);
    check(ho == 0, "R11", ho, 0, "high-side after fault with command still high");
    hin = 0;
    repeat (5) @(negedge clk);
    hin = 1;
    repeat (4) @(negedge clk);
    check(ho == 1, "R11", ho, 1, "high-side after commands seen low");

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule